// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block sits between a pair of window comparators and a gate-drive sequencer. A controller's PWM line can rest high, low, or at a middle level. The middle level is also where an undriven line settles. Two comparator bits say whether the line is above the upper threshold and whether it is above the lower threshold. The block sorts each sample into one of three regions and issues a high-side request, a low-side request, or a shutdown.

A short trip through the middle region, such as the one that happens on every ordinary edge, must not disturb the drive. The block counts consecutive middle samples and declares shutdown only after `HOLD_CYCLES` of them. Shutdown forces both requests low. A valid high or low level overrides the middle state as soon as it arrives, with no extra filtering. After reset the block stays in shutdown until it sees its first valid level.

Top module: `tristate_pwm_decoder`

## Requirements
- R1: The region encoding is fixed. `above_upper=1, above_lower=1` is HIGH and gives `hs_req=1, ls_req=0, shutdown=0`. `above_upper=0, above_lower=0` is LOW and gives `hs_req=0, ls_req=1, shutdown=0`. `above_upper=0, above_lower=1` is the middle region.
- R2: The impossible code `above_upper=1, above_lower=0` behaves exactly like the middle region.
- R3: With the default two synchronizer stages, a change of the comparator inputs reaches the outputs after the third rising clock edge.
- R4: A middle-region visit seen for fewer than `HOLD_CYCLES` consecutive synchronized samples is ignored. The previous request stays asserted and `shutdown` stays 0.
- R5: When the synchronized input stays in the middle region for `HOLD_CYCLES` consecutive samples, `shutdown` goes to 1. This happens on the edge that takes the `HOLD_CYCLES`-th such sample, which is edge `HOLD_CYCLES+2` after the input enters the region.
- R6: While `shutdown` is 1, both `hs_req` and `ls_req` are 0, and they are never 1 at the same time.
- R7: When the input leaves a valid shutdown, the new level is obeyed directly. The request it asks for appears with the same latency as in R3.
- R8: The hold-off count restarts each time the input re-enters the middle region. Two sub-threshold visits separated by a single valid sample never cause shutdown.
- R9: Once `shutdown` is set, it holds for as long as the input stays in the middle region, however long that is.
- R10: While reset is active and after it is released, the outputs show `shutdown=1` with both requests 0. They stay that way until the first valid HIGH or LOW sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_upper | input | 1 | Comparator: input above upper window threshold |
| above_lower | input | 1 | Comparator: input above lower window threshold |
| hs_req | output | 1 | Request high-side switch on |
| ls_req | output | 1 | Request low-side switch on |
| shutdown | output | 1 | Middle-region shutdown in force |

## Verification
The bench builds the decoder with `HOLD_CYCLES=4` and the default two synchronizer stages. This keeps the hold-off boundary small enough to sweep every middle-visit length from one sample to several times the threshold. Each length is combined with both preceding levels, both exit levels, and both middle codes, and the expected outputs are checked after every edge. That exposes the exact edge where shutdown appears, the exact exit latency, the count restart after a one-sample gap, and the saturation during long visits.

// File: rtl/tristate_pwm_decoder.sv
module tristate_pwm_decoder #(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_upper,
  input  logic above_lower,
  output logic hs_req,
  output logic ls_req,
  output logic shutdown
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] up_sync, lo_sync;
  logic                   drive_q, shut_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_sync <= '0;
      lo_sync <= '1;
    end else begin
      up_sync <= {up_sync[SYNC_STAGES-2:0], above_upper};
      lo_sync <= {lo_sync[SYNC_STAGES-2:0], above_lower};
    end

  wire up_s     = up_sync[SYNC_STAGES-1];
  wire lo_s     = lo_sync[SYNC_STAGES-1];
  wire lvl_high = up_s & lo_s;
  wire lvl_low  = ~up_s & ~lo_s;
  wire in_mid   = ~(lvl_high | lvl_low);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drive_q <= 1'b0;
      shut_q  <= 1'b1;
      cnt_q   <= '0;
    end else if (!in_mid) begin
      drive_q <= lvl_high;
      shut_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!shut_q) begin
      if (cnt_q == CNT_LAST) shut_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end

  assign hs_req   = ~shut_q & drive_q;
  assign ls_req   = ~shut_q & ~drive_q;
  assign shutdown = shut_q;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req) && !(shutdown && (hs_req || ls_req)));

  assert_high_obeyed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_high |=> (hs_req && !shutdown));

  assert_low_obeyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_low |=> (ls_req && !shutdown));

  assert_shut_needs_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut_q) |-> ($past(in_mid) && $past(cnt_q) == CNT_LAST));

  assert_shut_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && in_mid) |=> shut_q);

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
endmodule

// File: tb/tristate_pwm_decoder_test.sv
module tristate_pwm_decoder_test;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0, above_upper = 0, above_lower = 1;
  logic hs_req, ls_req, shutdown;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  tristate_pwm_decoder #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .above_upper(above_upper), .above_lower(above_lower),
    .hs_req(hs_req), .ls_req(ls_req), .shutdown(shutdown));

  task automatic chk(input string tag, input bit exp_shut, input bit exp_cmd);
    bit exp_hs = !exp_shut && exp_cmd;
    bit exp_ls = !exp_shut && !exp_cmd;
    checks++;
    if (shutdown !== exp_shut || hs_req !== exp_hs || ls_req !== exp_ls) begin
      fails++;
      $display("FAIL %s: got shut=%b hs=%b ls=%b exp shut=%b hs=%b ls=%b",
               tag, shutdown, hs_req, ls_req, exp_shut, exp_hs, exp_ls);
    end
  endtask

  task automatic drive_level(input bit high);
    above_upper = high; above_lower = high;
  endtask

  task automatic drive_mid(input bit odd);
    above_upper = odd; above_lower = !odd;
  endtask

  task automatic settle(input bit lvl);
    drive_level(lvl);
    repeat (4) @(negedge clk);
    chk("R1", 0, lvl);
  endtask

  // mid visit of L samples then exit; per-edge expectations computed arithmetically
  task automatic visit(input bit prior, input int L, input bit odd, input bit exit_lvl);
    settle(prior);
    drive_mid(odd);
    for (int j = 1; j <= L + 3; j++) begin
      int  seen;
      bit  exited, es;
      string tag;
      @(negedge clk);
      seen   = (j < 3) ? 0 : ((j - 2 < L) ? j - 2 : L);
      exited = (j >= L + 3);
      es     = !exited && (seen >= HOLD);
      if (exited)            tag = (L >= HOLD) ? "R7" : "R3";
      else if (odd)          tag = "R2";
      else if (es && j > HOLD + 2) tag = "R9";
      else if (es)           tag = "R5";
      else                   tag = "R4";
      chk(tag, es, exited ? exit_lvl : prior);
      if (j == L) drive_level(exit_lvl);
    end
  endtask

  initial begin
    drive_level(1);
    repeat (3) @(negedge clk);
    chk("R10", 1, 0);
    drive_mid(0);
    rst_n = 1;
    for (int k = 0; k < 3 * HOLD; k++) begin
      @(negedge clk);
      chk("R10", 1, 0);
    end
    drive_level(1);
    @(negedge clk); chk("R10", 1, 0);
    @(negedge clk); chk("R3", 1, 0);
    @(negedge clk); chk("R3", 0, 1);

    for (int odd = 0; odd < 2; odd++)
      for (int prior = 0; prior < 2; prior++)
        for (int ex = 0; ex < 2; ex++)
          for (int L = 1; L <= 3 * HOLD; L++)
            visit(prior[0], L, odd[0], ex[0]);

    // R8: two sub-threshold visits separated by one valid sample
    settle(0);
    drive_mid(0);
    repeat (HOLD - 1) @(negedge clk);
    drive_level(0);
    @(negedge clk);
    drive_mid(0);
    repeat (HOLD - 1) @(negedge clk);
    drive_level(0);
    for (int k = 0; k < 2 * HOLD + 3; k++) begin
      chk("R8", 0, 0);
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule